// File: doc/BRIEF.md
# Auto-Negotiation Next-Page Transmit Register

This block holds the next page that an Ethernet PHY offers to its link partner during the next-page phase of auto-negotiation. Management software writes the page contents through a simple register port. The block then presents a 16-bit next-page link control word to the negotiation transmitter.

Software controls four fields: the more-pages flag, the page format select, the second acknowledge flag and an 11-bit code field. Two bits are not stored from software. The reserved bit is always zero. The toggle bit is generated in hardware. The negotiation logic pulses `restart` when a new next-page exchange begins. That seeds the toggle from the inverse of bit 11 of the base page. The negotiation logic then pulses `page_sent` after each page goes out, and that flips the toggle. A one-cycle `page_valid` pulse after every accepted write tells the negotiation logic that a fresh page is ready.

Top module: `an_next_page_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tx_word` is 0, `page_valid` is 0, and a read of the register returns 0. This covers all stored fields and the toggle state.
- R2: A write with `reg_wr_en` high and `reg_addr` equal to 8 stores the following data bits, which appear in `tx_word` and in the read data from the next cycle on:
  - bit 15: more pages follow
  - bit 13: message page (1) or unformatted page (0)
  - bit 12: able to comply (1) or not (0)
  - bits 10:0: code field
- R3: Bit 14 of both `tx_word` and the read data is always 0, whatever value was written to it.
- R4: Bit 11 cannot be written. Bit 11 of both `tx_word` and the read data shows the current hardware toggle value.
- R5: A `restart` pulse loads the toggle with the inverse of `base_word[11]`. The new value is visible in the next cycle.
- R6: A `page_sent` pulse without `restart` inverts the toggle in the next cycle. With neither input high, the toggle holds.
- R7: When `restart` and `page_sent` are high in the same cycle, the restart load wins.
- R8: A write to any address other than 8 changes no stored field. A read at any address other than 8 returns 0.
- R9: `page_valid` is high for exactly the one cycle after each accepted write. Back-to-back writes keep it high in each following cycle.
- R10: While `reg_addr` is 8, the read data equals `tx_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Management register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (0 when not selected) |
| base_word | input | 16 | Base page link control word; only bit 11 is used |
| page_sent | input | 1 | One-cycle pulse per next page transmitted |
| restart | input | 1 | One-cycle pulse starting a new next-page exchange |
| tx_word | output | 16 | Next-page link control word for the transmitter |
| page_valid | output | 1 | One-cycle pulse after each accepted write |

## Verification
The stimulus covers several kinds of writes:
- all-ones and all-zeros data, which expose a stuck bit or a wrongly stored reserved or toggle bit;
- alternating patterns, which show up swapped field positions;
- writes to neighbouring addresses, which must leave the page untouched.

The toggle is exercised in three ways:
- restarts with base bit 11 at both values, which separate a plain copy from an inversion;
- runs of `page_sent` pulses with gaps between them, which separate flipping from holding;
- a restart and a page-sent pulse in the same cycle, which settles their priority.

Writes that coincide with page-sent pulses, and back-to-back writes, check that the fields, the toggle and the valid pulse stay independent.

// File: rtl/an_np_pkg.sv
package an_np_pkg;
    localparam int WORD_W   = 16;
    localparam int CODE_W   = 11;
    localparam int NP_BIT   = 15;
    localparam int RSVD_BIT = 14;
    localparam int MP_BIT   = 13;
    localparam int ACK2_BIT = 12;
    localparam int TOG_BIT  = 11;

    typedef struct packed {
        logic              more_pages;
        logic              msg_page;
        logic              can_comply;
        logic [CODE_W-1:0] code;
    } np_fields_t;

    function automatic logic [WORD_W-1:0] pack_word(np_fields_t f, logic tog);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[NP_BIT]              = f.more_pages;
        w[RSVD_BIT]            = 1'b0;
        w[MP_BIT]              = f.msg_page;
        w[ACK2_BIT]            = f.can_comply;
        w[TOG_BIT]             = tog;
        w[CODE_W-1:0]          = f.code;
        return w;
    endfunction
endpackage

// File: rtl/an_np_field_store.sv
module an_np_field_store
    import an_np_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  np_fields_t wr_fields,
    output np_fields_t fields,
    output logic       wr_pulse
);
    typedef struct packed {
        np_fields_t f;
        logic       pulse;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = wr_hit;
        if (wr_hit) begin
            st_d.f = wr_fields;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields   = st_q.f;
    assign wr_pulse = st_q.pulse;

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(fields)); // R8
    AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> wr_pulse); // R9
    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> !wr_pulse); // R9
endmodule

// File: rtl/an_np_toggle_gen.sv
module an_np_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic reload,
    input  logic base_tog,
    output logic toggle
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (reload) begin
            tog_d = ~base_tog;
        end else if (advance) begin
            tog_d = ~tog_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign toggle = tog_q;

    AST_RELOAD_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> toggle == !$past(base_tog)); // R5
    AST_ADVANCE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reload) |=> toggle != $past(toggle)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !reload) |=> $stable(toggle)); // R6
    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && reload) |=> toggle == !$past(base_tog)); // R7
endmodule

// File: rtl/an_next_page_reg.sv
module an_next_page_reg
    import an_np_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] base_word,
    input  logic              page_sent,
    input  logic              restart,
    output logic [WORD_W-1:0] tx_word,
    output logic              page_valid
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

    logic       sel;
    logic       wr_hit;
    logic       tog;
    np_fields_t wr_fields;
    np_fields_t cur_fields;
    logic       unused_bits;

    assign sel    = (reg_addr == SEL_ADDR);
    assign wr_hit = sel && reg_wr_en;

    always_comb begin
        wr_fields            = '0;
        wr_fields.more_pages = reg_wdata[NP_BIT];
        wr_fields.msg_page   = reg_wdata[MP_BIT];
        wr_fields.can_comply = reg_wdata[ACK2_BIT];
        wr_fields.code       = reg_wdata[CODE_W-1:0];
    end

    assign unused_bits = ^{reg_wdata[RSVD_BIT], reg_wdata[TOG_BIT],
                           base_word[WORD_W-1:TOG_BIT+1], base_word[TOG_BIT-1:0]};

    an_np_field_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_fields (wr_fields),
        .fields    (cur_fields),
        .wr_pulse  (page_valid)
    );

    an_np_toggle_gen u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (page_sent),
        .reload   (restart),
        .base_tog (base_word[TOG_BIT]),
        .toggle   (tog)
    );

    assign tx_word   = pack_word(cur_fields, tog);
    assign reg_rdata = sel ? pack_word(cur_fields, tog) : '0;

    AST_READ_TRACKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> reg_rdata == tx_word); // R10
    AST_UNSELECTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> reg_rdata == '0); // R8
    AST_CODE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> tx_word[CODE_W-1:0] == $past(reg_wdata[CODE_W-1:0])); // R2
    AST_FLAGS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (tx_word[NP_BIT] == $past(reg_wdata[NP_BIT])) &&
                   (tx_word[MP_BIT] == $past(reg_wdata[MP_BIT])) &&
                   (tx_word[ACK2_BIT] == $past(reg_wdata[ACK2_BIT]))); // R2
endmodule

// File: tb/tb_an_next_page_reg.sv
`timescale 1ns/1ps
module tb_an_next_page_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  reg_addr;
    logic        reg_wr_en;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [15:0] base_word;
    logic        page_sent;
    logic        restart;
    logic [15:0] tx_word;
    logic        page_valid;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_np, m_mp, m_ack, m_code, m_tog, m_valid;

    always #5 clk = ~clk;

    an_next_page_reg dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_word(base_word),
        .page_sent(page_sent), .restart(restart), .tx_word(tx_word),
        .page_valid(page_valid)
    );

    function automatic logic [15:0] model_word();
        logic [15:0] w;
        w = '0;
        w[15]   = m_np[0];
        w[13]   = m_mp[0];
        w[12]   = m_ack[0];
        w[11]   = m_tog[0];
        w[10:0] = m_code[10:0];
        return w;
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, "tx_word", tx_word, model_word());
        check(req, "page_valid", {15'd0, page_valid}, m_valid[15:0]);
        check(req, "reg_rdata", reg_rdata, (reg_addr == 5'd8) ? model_word() : 16'h0000);
        check(req, "reserved bit", {15'd0, tx_word[14]}, 16'h0000); // R3
    endtask

    // one clock: drive inputs, model the edge, compare after the edge
    task automatic step(string req, logic [4:0] a, logic we, logic [15:0] wd,
                        logic [15:0] bw, logic ps, logic rs);
        @(negedge clk);
        reg_addr = a; reg_wr_en = we; reg_wdata = wd;
        base_word = bw; page_sent = ps; restart = rs;
        @(posedge clk);
        m_valid = (we && a == 5'd8) ? 1 : 0;
        if (we && a == 5'd8) begin
            m_np = wd[15]; m_mp = wd[13]; m_ack = wd[12]; m_code = wd[10:0];
        end
        if (rs) m_tog = bw[11] ? 0 : 1;
        else if (ps) m_tog = 1 - m_tog;
        #1;
        compare_all(req);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_addr = 5'd8; reg_wr_en = 1'b0; reg_wdata = '0;
        base_word = '0; page_sent = 1'b0; restart = 1'b0;
        m_np = 0; m_mp = 0; m_ack = 0; m_code = 0; m_tog = 0; m_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare_all("R1");

        // all ones: reserved and toggle bits must not stick
        step("R2", 5'd8, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        check("R4", "bit11 after write", {15'd0, tx_word[11]}, 16'h0000);
        step("R9", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
        step("R2", 5'd8, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0);
        step("R2", 5'd8, 1'b1, 16'hAAAA, 16'h0000, 1'b0, 1'b0);
        step("R9", 5'd8, 1'b1, 16'h5555, 16'h0000, 1'b0, 1'b0);
        step("R9", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);

        // restart with base bit11 = 0 gives toggle 1
        step("R5", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1);
        check("R5", "toggle after restart", {15'd0, tx_word[11]}, 16'h0001);
        // restart with base bit11 = 1 gives toggle 0
        step("R5", 5'd8, 1'b0, 16'h0000, 16'h0800, 1'b0, 1'b1);
        check("R5", "toggle after restart", {15'd0, tx_word[11]}, 16'h0000);

        // page-sent pulses with gaps
        for (int i = 0; i < 6; i++) begin
            step("R6", 5'd8, 1'b0, 16'h0000, 16'hF7FF, 1'b1, 1'b0);
            step("R6", 5'd8, 1'b0, 16'h0000, 16'hF7FF, 1'b0, 1'b0);
        end
        // writing bit 11 has no effect on the toggle
        step("R4", 5'd8, 1'b1, 16'h0800, 16'h0000, 1'b0, 1'b0);
        step("R4", 5'd8, 1'b1, 16'hF7FF, 16'h0000, 1'b0, 1'b0);

        // restart and page_sent together: restart wins
        step("R7", 5'd8, 1'b0, 16'h0000, 16'h0800, 1'b1, 1'b1);
        step("R7", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1);

        // other addresses: writes ignored, reads zero
        step("R8", 5'd7, 1'b1, 16'h1234, 16'h0000, 1'b0, 1'b0);
        step("R8", 5'd9, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        step("R8", 5'd24, 1'b1, 16'h0000, 16'h0000, 1'b1, 1'b0);
        step("R10", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);

        // write together with page_sent
        for (int i = 0; i < 8; i++) begin
            step("R2", 5'd8, 1'b1, 16'h9000 + 16'(i * 97), 16'h0000, i[0], 1'b0);
        end
        step("R9", 5'd3, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
        step("R10", 5'd8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule